// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread of a multithreaded core may use the fetch port. Each thread reports a 3-bit fetch state and an active bit. A thread that is active and in a fetchable state is a candidate. The block returns a grant flag and the index of the chosen thread, both combinational from the current inputs and the stored order.

In round-robin mode the block keeps an ordered list of thread indices. The grant goes to the first candidate found when walking the list from its head. When the fetch logic consumes the grant by pulsing `fetch_take`, the granted thread is taken out of its place and appended at the tail. The list update takes one clock edge. In single-thread mode, which is legal only for a one-thread build, thread 0 is granted whenever it is a candidate.

Top module: `fetch_thread_picker`

## Requirements
- R1: Fetch state codes 0 (running), 1 (idle) and 2 (line filled) make a thread fetchable. Codes 3 (squashing), 4 (blocked), 5 (waiting on memory), 6 (waiting to resend) and 7 (trap pending) make it unfetchable.
- R2: A thread whose bit in `thread_active` is 0 is never granted, whatever its state.
- R3: In round-robin mode, the grant goes to the first thread, walking the order list from head to tail, that is both active and fetchable.
- R4: On a clock edge with `fetch_take` and `grant_valid` both high, the granted thread moves to the tail of the list. The other entries keep their relative order. The list always stays a permutation of 0..NUM_THREADS-1.
- R5: Without `fetch_take` the order list does not change, whatever the status inputs do.
- R6: When no thread is a candidate, `grant_valid` is 0 and `grant_tid` is 0.
- R7: After reset the list holds 0,1,..,NUM_THREADS-1 from head to tail. With all threads fetchable, repeated takes therefore grant 0,1,2,3,0 for four threads.
- R8: In single-thread mode, thread 0 is granted exactly when it is active and fetchable. Building single-thread mode with more than one thread is rejected at elaboration.
- R9: A `fetch_take` pulse while `grant_valid` is 0 leaves the list unchanged.
- R10: `grant_valid` and `grant_tid` follow a status or active change within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_status | input | NUM_THREADS*3 | Per-thread fetch state; thread i occupies bits [3i+2:3i] |
| thread_active | input | NUM_THREADS | Per-thread active mask |
| fetch_take | input | 1 | Grant consumed this cycle; rotates the order list |
| grant_valid | output | 1 | A thread is granted |
| grant_tid | output | TID_W | Granted thread index, 0 when no grant |

## Verification
The bench builds two instances. The first is a four-thread round-robin selector, which brings in list rotation across all positions: skipping an ineligible head, moving a thread from the middle of the list, and held or ignored take strobes. The second is a one-thread single-thread selector, which brings the fixed thread-0 policy and its gating by the active bit and all eight state codes within reach. The four-thread build is small enough that the bench tracks the full order list itself and predicts every grant.

// File: rtl/fpick_pkg.sv
package fpick_pkg;

  localparam int FS_W = 3;

  typedef enum logic [FS_W-1:0] {
    FS_RUN      = 3'd0,
    FS_IDLE     = 3'd1,
    FS_FILLED   = 3'd2,
    FS_SQUASH   = 3'd3,
    FS_BLOCKED  = 3'd4,
    FS_MEMWAIT  = 3'd5,
    FS_RESEND   = 3'd6,
    FS_TRAP     = 3'd7
  } fetch_state_e;

  function automatic logic state_fetchable(input logic [FS_W-1:0] st);
    return (st == FS_RUN) || (st == FS_IDLE) || (st == FS_FILLED);
  endfunction

endpackage

// File: rtl/fpick_elig.sv
module fpick_elig
  import fpick_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*FS_W-1:0] status_flat,
  input  logic [N-1:0]      active,
  output logic [N-1:0]      elig
);

  for (genvar g = 0; g < N; g++) begin : g_thr
    assign elig[g] = active[g] & state_fetchable(status_flat[g*FS_W +: FS_W]);
  end

endmodule

// File: rtl/fpick_order.sv
module fpick_order #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [TW-1:0] upd_pos,
  output logic [N*TW-1:0] list_flat
);

  logic [TW-1:0] ord_q [N];
  logic [TW-1:0] ord_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (i < int'(upd_pos))   ord_d[i] = ord_q[i];
      else if (i < N - 1)      ord_d[i] = ord_q[i+1];
      else                     ord_d[i] = ord_q[upd_pos];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ord_q[i] <= TW'(i);
    end else if (upd_en) begin
      for (int i = 0; i < N; i++) ord_q[i] <= ord_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign list_flat[g*TW +: TW] = ord_q[g];
  end

  logic perm_ok;
  always_comb begin
    int cnt;
    perm_ok = 1'b1;
    for (int v = 0; v < N; v++) begin
      cnt = 0;
      for (int i = 0; i < N; i++)
        if (ord_q[i] == TW'(v)) cnt++;
      if (cnt != 1) perm_ok = 1'b0;
    end
  end

  // R4
  order_is_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) perm_ok);

endmodule

// File: rtl/fpick_scan.sv
module fpick_scan #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N*TW-1:0] list_flat,
  input  logic [N-1:0]    elig,
  output logic            hit,
  output logic [TW-1:0]   hit_pos,
  output logic [TW-1:0]   hit_tid
);

  always_comb begin
    logic [TW-1:0] ent;
    hit     = 1'b0;
    hit_pos = '0;
    hit_tid = '0;
    for (int i = N - 1; i >= 0; i--) begin
      ent = list_flat[i*TW +: TW];
      if (elig[ent]) begin
        hit     = 1'b1;
        hit_pos = TW'(i);
        hit_tid = ent;
      end
    end
  end

endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker
  import fpick_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter bit ROUND_ROBIN = 1'b1,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS*FS_W-1:0]  thread_status,
  input  logic [NUM_THREADS-1:0]       thread_active,
  input  logic                         fetch_take,
  output logic                         grant_valid,
  output logic [TID_W-1:0]             grant_tid
);

  // R8
  initial begin : cfg_chk
    single_cfg_chk: assert (ROUND_ROBIN || NUM_THREADS == 1)
      else $error("single-thread policy needs NUM_THREADS == 1");
  end

  logic [NUM_THREADS-1:0] elig;

  fpick_elig #(.N(NUM_THREADS)) u_elig (
    .status_flat (thread_status),
    .active      (thread_active),
    .elig        (elig)
  );

  if (ROUND_ROBIN) begin : g_rr
    logic [NUM_THREADS*TID_W-1:0] list_flat;
    logic [TID_W-1:0]             pos;
    logic                         upd_en;

    assign upd_en = fetch_take & grant_valid;

    fpick_order #(.N(NUM_THREADS), .TW(TID_W)) u_order (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (upd_en),
      .upd_pos   (pos),
      .list_flat (list_flat)
    );

    fpick_scan #(.N(NUM_THREADS), .TW(TID_W)) u_scan (
      .list_flat (list_flat),
      .elig      (elig),
      .hit       (grant_valid),
      .hit_pos   (pos),
      .hit_tid   (grant_tid)
    );

    // R1
    grant_is_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> elig[grant_tid]);
    // R6
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |-> (!grant_valid && grant_tid == '0));
    // R4
    tail_takes_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (list_flat[(NUM_THREADS-1)*TID_W +: TID_W] == $past(grant_tid)));
    // R5
    list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_take |=> $stable(list_flat));
    // R9
    take_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_take && !grant_valid) |=> $stable(list_flat));
  end else begin : g_single
    assign grant_valid = elig[0];
    assign grant_tid   = '0;

    // R8
    single_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_tid == '0 && (grant_valid == elig[0]));
  end

endmodule

// File: tb/fetch_thread_picker_test.sv
`timescale 1ns/1ps
module fetch_thread_picker_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] st_b [N];
  logic [N-1:0] act_b;
  logic take_b;
  logic gv;
  logic [1:0] gt;
  logic [2:0] st1;
  logic act1;
  logic gv1;
  logic [0:0] gt1;

  int tests = 0;
  int fails = 0;
  int q [N];

  always #4 clk = ~clk;

  fetch_thread_picker #(.NUM_THREADS(N), .ROUND_ROBIN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .thread_status({st_b[3], st_b[2], st_b[1], st_b[0]}),
    .thread_active(act_b), .fetch_take(take_b),
    .grant_valid(gv), .grant_tid(gt));

  fetch_thread_picker #(.NUM_THREADS(1), .ROUND_ROBIN(1'b0)) uut_one (
    .clk(clk), .rst_n(rst_n), .thread_status(st1), .thread_active(act1),
    .fetch_take(take_b), .grant_valid(gv1), .grant_tid(gt1));

  function automatic bit ok_state(input logic [2:0] s);
    return s <= 3'd2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_model(input string req);
    int ev = 0;
    int et = 0;
    for (int i = N - 1; i >= 0; i--)
      if (act_b[q[i]] && ok_state(st_b[q[i]])) begin ev = 1; et = q[i]; end
    chk({req, " valid"}, int'(gv), ev);
    chk({req, " tid"}, int'(gt), et);
  endtask

  task automatic set_all(input logic [2:0] s, input logic [N-1:0] a);
    @(negedge clk);
    for (int i = 0; i < N; i++) st_b[i] = s;
    act_b = a;
    #1;
  endtask

  task automatic do_take();
    int p = -1;
    int g;
    for (int i = N - 1; i >= 0; i--)
      if (act_b[q[i]] && ok_state(st_b[q[i]])) p = i;
    take_b = 1'b1;
    @(negedge clk);
    take_b = 1'b0;
    if (p >= 0) begin
      g = q[p];
      for (int i = p; i < N - 1; i++) q[i] = q[i+1];
      q[N-1] = g;
    end
    #1;
  endtask

  task automatic t_reset();
    set_all(3'd0, 4'hF);
    chk("R7 head after reset", int'(gt), 0);
    for (int k = 0; k < 5; k++) begin
      chk("R7 reset order", int'(gt), k % N);
      chk_model("R4 rotate");
      do_take();
    end
  endtask

  task automatic t_codes();
    for (int c = 0; c < 8; c++) begin
      set_all(3'd4, 4'hF);
      st_b[2] = 3'(c);
      #1;
      chk("R10 same-cycle", int'(gv), (c <= 2) ? 1 : 0);
      chk_model("R1 code");
    end
  endtask

  task automatic t_inactive();
    set_all(3'd0, 4'b0000);
    chk_model("R2 none active");
    act_b = 4'b0100;
    #1;
    chk("R2 only active", int'(gt), 2);
    act_b = 4'b1010;
    #1;
    chk_model("R2 mask");
    do_take();
    set_all(3'd0, 4'hF);
    chk_model("R4 after mask take");
  endtask

  task automatic t_skip();
    set_all(3'd0, 4'hF);
    st_b[q[0]] = 3'd3;
    st_b[q[1]] = 3'd7;
    #1;
    chk_model("R3 skip head");
    chk("R3 third in list", int'(gt), q[2]);
    do_take();
    set_all(3'd1, 4'hF);
    chk_model("R4 middle to tail");
    for (int k = 0; k < N; k++) begin
      chk_model("R4 order walk");
      do_take();
    end
  endtask

  task automatic t_hold();
    int h;
    set_all(3'd0, 4'hF);
    h = q[0];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      st_b[k % N] = 3'(k + 3);
      act_b = 4'(k + 5);
      #1;
      chk_model("R5 changing inputs");
    end
    set_all(3'd2, 4'hF);
    chk("R5 head held", int'(gt), h);
  endtask

  task automatic t_none();
    int h;
    set_all(3'd5, 4'hF);
    chk("R6 no valid", int'(gv), 0);
    chk("R6 tid zero", int'(gt), 0);
    h = q[0];
    do_take();
    do_take();
    set_all(3'd0, 4'hF);
    chk("R9 take ignored", int'(gt), h);
    chk_model("R9 list intact");
  endtask

  task automatic t_single();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      st1 = 3'(c);
      act1 = 1'b1;
      #1;
      chk("R8 single state", int'(gv1), (c <= 2) ? 1 : 0);
      chk("R8 single tid", int'(gt1), 0);
    end
    act1 = 1'b0;
    st1 = 3'd0;
    #1;
    chk("R8 single inactive", int'(gv1), 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin st_b[i] = 3'd0; q[i] = i; end
    act_b = '1;
    take_b = 1'b0;
    st1 = 3'd0;
    act1 = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_inactive();
    t_skip();
    t_hold();
    t_none();
    t_single();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule